// File: doc/BRIEF.md
# Bridge Configuration Register File

This block holds the configuration space of a bus bridge. The space has 1024 words of 32 bits and is reached through a simple word-addressed port. A request carries a write flag, a word address, four byte selects and write data. Every plain access is answered one cycle later with an acknowledge, and reads also return the word. The space contains:

- a standard type-0 header, with identity, command bits, class code, cache-line size and latency timer, interrupt line and pin, and six base address registers;
- two banks of six address-translation images, one for the remote side and one for the local side. Each image has a control register, a base address, an address mask and a translation address;
- error-logging enables, a configuration-cycle address register and an interrupt-control register.

Every register applies its own mask of implemented bits. Unimplemented bits and hardwired fields ignore writes. All decoded control fields are driven out as individual ports, so the rest of the bridge can use them directly.

Two word offsets are windows for operations that happen elsewhere: configuration data at 0x284 and interrupt acknowledge at 0x288. A plain access to either of them is never acknowledged here. Instead, `pass_hit` is raised so that the owning logic can complete the access. Local image 0 always maps the register space itself and cannot be reprogrammed. The parameter `HOST_MODE` selects the class code, host bridge or other bridge.

The reset input is asynchronous and active low. Inside the block its release is synchronised over two flops, so registers leave reset on the second rising edge after `rst_n` rises.

Top module: `cfg_regfile`

## Requirements
- R1: A request to any address other than the two pass-through windows produces `ack` high in the following cycle. For a read, `rdata` carries the register value as it was before that cycle's edge. `ack` and `pass_hit` are low in any cycle that follows a cycle with no request.
- R2: A request to byte offset 0x284 (configuration data) or 0x288 (interrupt acknowledge) is never acknowledged. Instead, `pass_hit` is high in the following cycle, and a write there changes no register.
- R3: Offset 0x000 reads {DEVICE_ID, VENDOR_ID}. Offset 0x008 reads {class code, REVISION}, where the class code is 0x060000 when HOST_MODE=1 and 0x068000 when HOST_MODE=0.
- R4: At offset 0x00C, only byte 0 (cache-line size) and byte 1 (latency timer) are writable, so an all-ones write reads back 0x0000_FFFF. The two bytes drive `cache_line` and `lat_timer`.
- R5: At offset 0x03C, byte 0 (interrupt line, `irq_line`) is writable. Bytes 3..1 are fixed at 0x1A, 0x08 and 0x01, so an all-ones write reads back 0x1A08_01FF.
- R6: At offset 0x004, the writable bits are: bit 0 I/O enable, bit 1 memory enable, bit 2 master enable, bit 6 parity response and bit 8 system-error enable. An all-ones write reads back 0x0000_0147, and each bit drives its own port.
- R7: Remote image n has its registers at 0x100+16n: +0 control, +4 base, +8 mask, +C translation. The base implements bits 31:12 plus a mapping bit 0 (reads 0xFFFF_F001 after all ones). Mask and translation implement bits 31:12 (0xFFFF_F000). Control implements bits 2:1 (0x6). Header offsets 0x010..0x024 alias the bases of remote images 0..5.
- R8: Local images 1..5 sit at 0x200+16n with the same layout. Base reads 0xFFFF_F001, mask and translation read 0xFFFF_F000, and control implements bits 2:0 (0x7) after all-ones writes.
- R9: Local image 0 is hardwired and ignores writes. Base reads {LOCK_BASE, 12'h000} with mapping bit 0, mask reads 0xFFFF_F000 (a 4 KB window), and translation and control read zero.
- R10: The configuration-cycle address register at 0x280 implements bits 23:2 and bit 0, so an all-ones write reads back 0x00FF_FFFD. Its low 24 bits drive `cyc_addr`.
- R11: Bit 0 at 0x1C0 (remote error logging enable) and bit 0 at 0x270 (local error logging enable) are writable and drive ports. The remote error address at 0x1C4 and the remote error data at 0x1C8 read zero.
- R12: The interrupt-control register at 0x290 holds the following bits, and an all-ones write reads back 0x8000_000F. Each bit drives its own port.
  - bit 0: local error interrupt enable
  - bit 1: parity error interrupt enable
  - bit 2: system error interrupt enable
  - bit 3: interrupt propagation enable
  - bit 31: software reset
- R13: A write changes only the bytes whose select bit is set.
- R14: After reset, every register reads zero except the fixed fields (R3, R5, R9). Addresses with no register read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one access per cycle it is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word address (byte offset / 4) |
| sel | input | 4 | Byte selects for writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `ack` |
| ack | output | 1 | Access completed, one cycle after the request |
| pass_hit | output | 1 | Access landed on a pass-through window |
| io_en | output | 1 | I/O space enable |
| mem_en | output | 1 | Memory space enable |
| mst_en | output | 1 | Bus master enable |
| perr_rsp_en | output | 1 | Parity error response enable |
| serr_en | output | 1 | System error enable |
| cache_line | output | 8 | Cache-line size |
| lat_timer | output | 8 | Latency timer |
| irq_line | output | 8 | Interrupt line |
| rmt_base | output | 20*N_IMG | Remote image base pages |
| rmt_map | output | N_IMG | Remote image mapping bits |
| rmt_mask | output | 20*N_IMG | Remote image mask pages |
| rmt_trans | output | 20*N_IMG | Remote image translation pages |
| rmt_ctrl | output | 2*N_IMG | Remote image control fields |
| loc_base | output | 20*N_IMG | Local image base pages |
| loc_map | output | N_IMG | Local image mapping bits |
| loc_mask | output | 20*N_IMG | Local image mask pages |
| loc_trans | output | 20*N_IMG | Local image translation pages |
| loc_ctrl | output | 3*N_IMG | Local image control fields |
| rmt_err_en | output | 1 | Remote error logging enable |
| loc_err_en | output | 1 | Local error logging enable |
| cyc_addr | output | 24 | Configuration-cycle address |
| soft_rst | output | 1 | Software reset request |
| serr_irq_en | output | 1 | System error interrupt enable |
| perr_irq_en | output | 1 | Parity error interrupt enable |
| lerr_irq_en | output | 1 | Local error interrupt enable |
| prop_irq_en | output | 1 | Interrupt propagation enable |

## Verification
The bench sweeps every one of the 1024 words three times:

1. reads from reset;
2. all-ones writes;
3. reads again.

Each readback is compared with a value computed from the offset. This pass catches the following errors:

- a wrong implemented-bit mask, which leaks a stray bit such as bit 1 of the cycle address or bit 11 of a base;
- a broken header alias, which leaves 0x010..0x024 at zero;
- a writable local image 0, which reads all ones instead of the register-space base;
- decode aliasing, which makes undefined words read nonzero.

The two pass-through windows are checked for a missing `ack` and a raised `pass_hit`. A decoder that completes them as plain registers would acknowledge instead. Partial-select writes then check that unselected bytes survive. A merge that ignores `sel` would clear the software-reset bit or the cache-line byte.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = DATA_W - PAGE_LSB;
  localparam int IDX_W    = 4;

  // header words
  localparam logic [ADDR_W-1:0] W_ID    = 10'h000;
  localparam logic [ADDR_W-1:0] W_CMD   = 10'h001;
  localparam logic [ADDR_W-1:0] W_CLASS = 10'h002;
  localparam logic [ADDR_W-1:0] W_MISC  = 10'h003;
  localparam logic [ADDR_W-1:0] W_BAR0  = 10'h004;
  localparam logic [ADDR_W-1:0] W_INTR  = 10'h00F;
  // bridge words
  localparam logic [ADDR_W-1:0] W_RERR_CTL = 10'h070;
  localparam logic [ADDR_W-1:0] W_RERR_ADR = 10'h071;
  localparam logic [ADDR_W-1:0] W_RERR_DAT = 10'h072;
  localparam logic [ADDR_W-1:0] W_LERR_CTL = 10'h09C;
  localparam logic [ADDR_W-1:0] W_CYC_ADR  = 10'h0A0;
  localparam logic [ADDR_W-1:0] W_CYC_DAT  = 10'h0A1;
  localparam logic [ADDR_W-1:0] W_IACK     = 10'h0A2;
  localparam logic [ADDR_W-1:0] W_INT_CTL  = 10'h0A4;
  localparam logic [ADDR_W-1:0] W_LOC0_BASE = 10'h081;

  // image regions: addr[9:6]
  localparam logic [3:0] RMT_REGION = 4'h1;
  localparam logic [3:0] LOC_REGION = 4'h2;

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_BASE  = 2'd1,
    SLOT_MASK  = 2'd2,
    SLOT_TRANS = 2'd3
  } slot_e;

  localparam logic [DATA_W-1:0] BASE_IMPL = 32'hFFFF_F001;
  localparam logic [DATA_W-1:0] PAGE_IMPL = 32'hFFFF_F000;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [3:0] sel);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{sel[b]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_mreg.sv
// One 32-bit register with a per-bit implemented mask; unimplemented bits
// are held at zero and their flops reduce to constants.
module cfg_mreg #(
  parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [31:0] bmask,
  output logic [31:0] q
);
  logic [31:0] wm;
  logic [31:0] q_nx;

  always_comb begin
    wm   = bmask & IMPL;
    q_nx = (q & ~wm) | (wdata & wm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_nx;
  end
endmodule

// File: rtl/cfg_img_bank.sv
module cfg_img_bank
  import cfgspace_pkg::*;
#(
  parameter int          N_IMG      = 6,
  parameter int          CTRL_LSB   = 1,
  parameter int          CTRL_W     = 2,
  parameter bit          LOCK_FIRST = 1'b0,
  parameter logic [19:0] LOCK_BASE  = 20'h0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        idx,
  input  slot_e                   slot,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [DATA_W-1:0]       bmask,
  output logic [DATA_W-1:0]       rd_word,
  output logic [N_IMG*PAGE_W-1:0] base_o,
  output logic [N_IMG-1:0]        map_o,
  output logic [N_IMG*PAGE_W-1:0] mask_o,
  output logic [N_IMG*PAGE_W-1:0] trans_o,
  output logic [N_IMG*CTRL_W-1:0] ctrl_o
);
  localparam logic [DATA_W-1:0] CTRL_IMPL = ((DATA_W'(1) << CTRL_W) - 1) << CTRL_LSB;

  logic [DATA_W-1:0] rq [N_IMG][4];

  for (genvar i = 0; i < N_IMG; i++) begin : g_img
    if (LOCK_FIRST && i == 0) begin : g_locked
      assign rq[i][0] = '0;
      assign rq[i][1] = {LOCK_BASE, 12'h000};
      assign rq[i][2] = PAGE_IMPL;
      assign rq[i][3] = '0;
    end else begin : g_prog
      for (genvar s = 0; s < 4; s++) begin : g_slot
        localparam logic [DATA_W-1:0] IM = (s == 0) ? CTRL_IMPL :
                                           (s == 1) ? BASE_IMPL : PAGE_IMPL;
        logic hit;
        assign hit = wr_en && (idx == IDX_W'(i)) && (slot == slot_e'(s));
        cfg_mreg #(.IMPL(IM)) u_reg (
          .clk(clk), .rst_n(rst_n), .wr_en(hit),
          .wdata(wdata), .bmask(bmask), .q(rq[i][s])
        );
      end
    end
    assign base_o[i*PAGE_W +: PAGE_W]  = rq[i][1][DATA_W-1:PAGE_LSB];
    assign map_o[i]                    = rq[i][1][0];
    assign mask_o[i*PAGE_W +: PAGE_W]  = rq[i][2][DATA_W-1:PAGE_LSB];
    assign trans_o[i*PAGE_W +: PAGE_W] = rq[i][3][DATA_W-1:PAGE_LSB];
    assign ctrl_o[i*CTRL_W +: CTRL_W]  = rq[i][0][CTRL_LSB +: CTRL_W];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_IMG; i++)
      if (idx == IDX_W'(i)) rd_word = rq[i][slot];
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfgspace_pkg::*;
#(
  parameter int          N_IMG     = 6,
  parameter bit          HOST_MODE = 1'b1,
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID = 16'h0C01,
  parameter logic [7:0]  REVISION  = 8'h03,
  parameter logic [19:0] LOCK_BASE = 20'hF0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    we,
  input  logic [9:0]              addr,
  input  logic [3:0]              sel,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic                    ack,
  output logic                    pass_hit,
  output logic                    io_en,
  output logic                    mem_en,
  output logic                    mst_en,
  output logic                    perr_rsp_en,
  output logic                    serr_en,
  output logic [7:0]              cache_line,
  output logic [7:0]              lat_timer,
  output logic [7:0]              irq_line,
  output logic [N_IMG*20-1:0]     rmt_base,
  output logic [N_IMG-1:0]        rmt_map,
  output logic [N_IMG*20-1:0]     rmt_mask,
  output logic [N_IMG*20-1:0]     rmt_trans,
  output logic [N_IMG*2-1:0]      rmt_ctrl,
  output logic [N_IMG*20-1:0]     loc_base,
  output logic [N_IMG-1:0]        loc_map,
  output logic [N_IMG*20-1:0]     loc_mask,
  output logic [N_IMG*20-1:0]     loc_trans,
  output logic [N_IMG*3-1:0]      loc_ctrl,
  output logic                    rmt_err_en,
  output logic                    loc_err_en,
  output logic [23:0]             cyc_addr,
  output logic                    soft_rst,
  output logic                    serr_irq_en,
  output logic                    perr_irq_en,
  output logic                    lerr_irq_en,
  output logic                    prop_irq_en
);
  localparam int          HDR_BARS = (N_IMG < 6) ? N_IMG : 6;
  localparam logic [23:0] CLASS    = HOST_MODE ? 24'h06_0000 : 24'h06_8000;
  localparam logic [31:0] INTR_FIX = 32'h1A08_0100;

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  // access decode
  logic            spc, plain, wr;
  logic [31:0]     bmask;
  logic            hdr_bar, rmt_hit, loc_hit;
  logic [IDX_W-1:0] rmt_idx, loc_idx;
  slot_e           rmt_slot, loc_slot;

  always_comb begin
    spc     = (addr == W_CYC_DAT) || (addr == W_IACK);
    plain   = req && !spc;
    wr      = plain && we;
    bmask   = lane_mask(sel);
    hdr_bar = (addr >= W_BAR0) && (int'(addr) < int'(W_BAR0) + HDR_BARS);
    rmt_hit = hdr_bar || ((addr[9:6] == RMT_REGION) && (int'(addr[5:2]) < N_IMG));
    loc_hit = (addr[9:6] == LOC_REGION) && (int'(addr[5:2]) < N_IMG);
    rmt_idx  = hdr_bar ? (addr[3:0] - 4'd4) : addr[5:2];
    rmt_slot = hdr_bar ? SLOT_BASE : slot_e'(addr[1:0]);
    loc_idx  = addr[5:2];
    loc_slot = slot_e'(addr[1:0]);
  end

  // header and control registers
  logic [31:0] cmd_q, misc_q, intr_q, rerr_q, lerr_q, cyc_q, ictl_q;

  cfg_mreg #(.IMPL(32'h0000_0147)) u_cmd (.clk(clk), .rst_n(rst_q_n),
    .wr_en(wr && addr == W_CMD), .wdata(wdata), .bmask(bmask), .q(cmd_q));
  cfg_mreg #(.IMPL(32'h0000_FFFF)) u_misc (.clk(clk), .rst_n(rst_q_n),
    .wr_en(wr && addr == W_MISC), .wdata(wdata), .bmask(bmask), .q(misc_q));
  cfg_mreg #(.IMPL(32'h0000_00FF)) u_intr (.clk(clk), .rst_n(rst_q_n),
    .wr_en(wr && addr == W_INTR), .wdata(wdata), .bmask(bmask), .q(intr_q));
  cfg_mreg #(.IMPL(32'h0000_0001)) u_rerr (.clk(clk), .rst_n(rst_q_n),
    .wr_en(wr && addr == W_RERR_CTL), .wdata(wdata), .bmask(bmask), .q(rerr_q));
  cfg_mreg #(.IMPL(32'h0000_0001)) u_lerr (.clk(clk), .rst_n(rst_q_n),
    .wr_en(wr && addr == W_LERR_CTL), .wdata(wdata), .bmask(bmask), .q(lerr_q));
  cfg_mreg #(.IMPL(32'h00FF_FFFD)) u_cyc (.clk(clk), .rst_n(rst_q_n),
    .wr_en(wr && addr == W_CYC_ADR), .wdata(wdata), .bmask(bmask), .q(cyc_q));
  cfg_mreg #(.IMPL(32'h8000_000F)) u_ictl (.clk(clk), .rst_n(rst_q_n),
    .wr_en(wr && addr == W_INT_CTL), .wdata(wdata), .bmask(bmask), .q(ictl_q));

  // image banks
  logic [31:0] rmt_rd, loc_rd;

  cfg_img_bank #(.N_IMG(N_IMG), .CTRL_LSB(1), .CTRL_W(2), .LOCK_FIRST(1'b0),
                 .LOCK_BASE(LOCK_BASE)) u_rmt (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr && rmt_hit), .idx(rmt_idx),
    .slot(rmt_slot), .wdata(wdata), .bmask(bmask), .rd_word(rmt_rd),
    .base_o(rmt_base), .map_o(rmt_map), .mask_o(rmt_mask),
    .trans_o(rmt_trans), .ctrl_o(rmt_ctrl));

  cfg_img_bank #(.N_IMG(N_IMG), .CTRL_LSB(0), .CTRL_W(3), .LOCK_FIRST(1'b1),
                 .LOCK_BASE(LOCK_BASE)) u_loc (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr && loc_hit), .idx(loc_idx),
    .slot(loc_slot), .wdata(wdata), .bmask(bmask), .rd_word(loc_rd),
    .base_o(loc_base), .map_o(loc_map), .mask_o(loc_mask),
    .trans_o(loc_trans), .ctrl_o(loc_ctrl));

  // read mux
  logic [31:0] rd_nx;
  always_comb begin
    if (rmt_hit)      rd_nx = rmt_rd;
    else if (loc_hit) rd_nx = loc_rd;
    else begin
      case (addr)
        W_ID:       rd_nx = {DEVICE_ID, VENDOR_ID};
        W_CMD:      rd_nx = cmd_q;
        W_CLASS:    rd_nx = {CLASS, REVISION};
        W_MISC:     rd_nx = misc_q;
        W_INTR:     rd_nx = INTR_FIX | intr_q;
        W_RERR_CTL: rd_nx = rerr_q;
        W_LERR_CTL: rd_nx = lerr_q;
        W_CYC_ADR:  rd_nx = cyc_q;
        W_INT_CTL:  rd_nx = ictl_q;
        default:    rd_nx = '0;
      endcase
    end
  end

  // response stage
  logic        ack_nx, pass_nx;
  always_comb begin
    ack_nx  = plain;
    pass_nx = req && spc;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ack      <= 1'b0;
      pass_hit <= 1'b0;
    end else begin
      ack      <= ack_nx;
      pass_hit <= pass_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   rdata <= '0;
    else if (plain) rdata <= rd_nx;
  end

  // decoded fields
  assign io_en       = cmd_q[0];
  assign mem_en      = cmd_q[1];
  assign mst_en      = cmd_q[2];
  assign perr_rsp_en = cmd_q[6];
  assign serr_en     = cmd_q[8];
  assign cache_line  = misc_q[7:0];
  assign lat_timer   = misc_q[15:8];
  assign irq_line    = intr_q[7:0];
  assign rmt_err_en  = rerr_q[0];
  assign loc_err_en  = lerr_q[0];
  assign cyc_addr    = cyc_q[23:0];
  assign lerr_irq_en = ictl_q[0];
  assign perr_irq_en = ictl_q[1];
  assign serr_irq_en = ictl_q[2];
  assign prop_irq_en = ictl_q[3];
  assign soft_rst    = ictl_q[31];
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk
  import cfgspace_pkg::*;
#(
  parameter logic [19:0] LOCK_BASE = 20'hF0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [9:0]  addr,
  input logic [3:0]  sel,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        ack,
  input logic        pass_hit,
  input logic [7:0]  cache_line
);
  logic       spc;
  logic [9:0] prev_addr;
  logic       prev_rd;

  assign spc = (addr == W_CYC_DAT) || (addr == W_IACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_rd   <= 1'b0;
    end else begin
      prev_addr <= addr;
      prev_rd   <= req && !we;
    end
  end

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req && !spc |=> ack);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ack && !pass_hit);  // R1
  AST_WINDOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req && spc |=> !ack && pass_hit);  // R2
  AST_CLS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr == W_MISC && sel[0] |=> cache_line == $past(wdata[7:0]));  // R4
  AST_INTR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ack && prev_rd && prev_addr == W_INTR |-> rdata[31:8] == 24'h1A_0801);  // R5
  AST_LOC0_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ack && prev_rd && prev_addr == W_LOC0_BASE |-> rdata == {LOCK_BASE, 12'h000});  // R9
  AST_CYCADDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ack && prev_rd && prev_addr == W_CYC_ADR |-> rdata[31:24] == 8'h00 && !rdata[1]);  // R10
endmodule

bind cfg_regfile cfg_regfile_chk #(.LOCK_BASE(LOCK_BASE)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .req(req), .we(we), .addr(addr), .sel(sel),
  .wdata(wdata), .rdata(rdata), .ack(ack), .pass_hit(pass_hit),
  .cache_line(cache_line));

// File: tb/tb_cfg_regfile.sv
`timescale 1ns/1ps
module tb_cfg_regfile;
  localparam int          N       = 6;
  localparam bit          HOST    = 1'b1;
  localparam logic [15:0] VEN     = 16'h1A2B;
  localparam logic [15:0] DEV     = 16'h0C01;
  localparam logic [7:0]  REV     = 8'h03;
  localparam logic [19:0] RBASE   = 20'hF0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [3:0] sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ack, pass_hit;
  logic io_en, mem_en, mst_en, perr_rsp_en, serr_en;
  logic [7:0] cache_line, lat_timer, irq_line;
  logic [N*20-1:0] rmt_base, rmt_mask, rmt_trans, loc_base, loc_mask, loc_trans;
  logic [N-1:0] rmt_map, loc_map;
  logic [N*2-1:0] rmt_ctrl;
  logic [N*3-1:0] loc_ctrl;
  logic rmt_err_en, loc_err_en, soft_rst, serr_irq_en, perr_irq_en, lerr_irq_en, prop_irq_en;
  logic [23:0] cyc_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_regfile #(.N_IMG(N), .HOST_MODE(HOST), .VENDOR_ID(VEN), .DEVICE_ID(DEV),
                .REVISION(REV), .LOCK_BASE(RBASE)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .sel(sel),
    .wdata(wdata), .rdata(rdata), .ack(ack), .pass_hit(pass_hit),
    .io_en(io_en), .mem_en(mem_en), .mst_en(mst_en), .perr_rsp_en(perr_rsp_en),
    .serr_en(serr_en), .cache_line(cache_line), .lat_timer(lat_timer),
    .irq_line(irq_line), .rmt_base(rmt_base), .rmt_map(rmt_map),
    .rmt_mask(rmt_mask), .rmt_trans(rmt_trans), .rmt_ctrl(rmt_ctrl),
    .loc_base(loc_base), .loc_map(loc_map), .loc_mask(loc_mask),
    .loc_trans(loc_trans), .loc_ctrl(loc_ctrl), .rmt_err_en(rmt_err_en),
    .loc_err_en(loc_err_en), .cyc_addr(cyc_addr), .soft_rst(soft_rst),
    .serr_irq_en(serr_irq_en), .perr_irq_en(perr_irq_en),
    .lerr_irq_en(lerr_irq_en), .prop_irq_en(prop_irq_en));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input int where);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at 0x%03h: actual=0x%08h expected=0x%08h", tag, where, act, exp);
    end
  endtask

  function automatic bit is_window(input int off);
    return off == 'h284 || off == 'h288;
  endfunction

  // expected word, computed from the requirement text
  function automatic logic [31:0] exp_word(input int off, input bit ones);
    int img, slot;
    if (off == 'h000) return {DEV, VEN};                                   // R3
    if (off == 'h004) return ones ? 32'h0000_0147 : 32'h0;                 // R6
    if (off == 'h008) return {(HOST ? 24'h06_0000 : 24'h06_8000), REV};    // R3
    if (off == 'h00C) return ones ? 32'h0000_FFFF : 32'h0;                 // R4
    if (off >= 'h010 && off <= 'h024) return ones ? 32'hFFFF_F001 : 32'h0; // R7
    if (off == 'h03C) return ones ? 32'h1A08_01FF : 32'h1A08_0100;         // R5
    if (off >= 'h100 && off < 'h100 + 16*N) begin                         // R7
      slot = (off >> 2) & 3;
      if (!ones) return 32'h0;
      return slot == 0 ? 32'h6 : slot == 1 ? 32'hFFFF_F001 : 32'hFFFF_F000;
    end
    if (off >= 'h200 && off < 'h200 + 16*N) begin                         // R8, R9
      img  = (off - 'h200) >> 4;
      slot = (off >> 2) & 3;
      if (img == 0)
        return slot == 1 ? {RBASE, 12'h000} : slot == 2 ? 32'hFFFF_F000 : 32'h0;
      if (!ones) return 32'h0;
      return slot == 0 ? 32'h7 : slot == 1 ? 32'hFFFF_F001 : 32'hFFFF_F000;
    end
    if (off == 'h1C0 || off == 'h270) return ones ? 32'h1 : 32'h0;        // R11
    if (off == 'h280) return ones ? 32'h00FF_FFFD : 32'h0;                 // R10
    if (off == 'h290) return ones ? 32'h8000_000F : 32'h0;                 // R12
    return 32'h0;                                                          // R14, R11
  endfunction

  task automatic acc(input logic w, input int off, input logic [3:0] s, input logic [31:0] d,
                     output logic [31:0] rd, output logic ak, output logic ph);
    @(negedge clk);
    req = 1'b1; we = w; addr = 10'(off >> 2); sel = s; wdata = d;
    @(negedge clk);
    rd = rdata; ak = ack; ph = pass_hit;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic sweep_read(input bit ones, input string tag);
    logic [31:0] rd; logic ak, ph;
    for (int w = 0; w < 1024; w++) begin
      acc(1'b0, w*4, 4'h0, 32'h0, rd, ak, ph);
      if (is_window(w*4)) begin
        chk("R2", {31'b0, ak}, 32'h0, w*4);
        chk("R2", {31'b0, ph}, 32'h1, w*4);
      end else begin
        chk("R1", {31'b0, ak}, 32'h1, w*4);
        chk(tag, rd, exp_word(w*4, ones), w*4);
      end
    end
  endtask

  initial begin
    logic [31:0] rd; logic ak, ph;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R14: reset state at the ports
    chk("R14", {30'b0, ack, pass_hit}, 32'h0, 0);
    chk("R14", {19'b0, serr_en, perr_rsp_en, mst_en, mem_en, io_en, cache_line}, 32'h0, 0);
    chk("R14", {lat_timer, irq_line, cyc_addr[15:0]}, 32'h0, 0);
    chk("R14", {25'b0, soft_rst, rmt_err_en, loc_err_en, lerr_irq_en, perr_irq_en,
                serr_irq_en, prop_irq_en}, 32'h0, 0);
    chk("R9", {12'b0, loc_base[19:0]}, {12'b0, RBASE}, 'h204);

    sweep_read(1'b0, "R14");

    // all-ones write over the full space, windows included
    for (int w = 0; w < 1024; w++) begin
      acc(1'b1, w*4, 4'hF, 32'hFFFF_FFFF, rd, ak, ph);
      chk(is_window(w*4) ? "R2" : "R1", {30'b0, ak, ph},
          is_window(w*4) ? 32'h1 : 32'h2, w*4);
    end

    sweep_read(1'b1, "R7");

    // ports after all-ones
    chk("R6", {27'b0, serr_en, perr_rsp_en, mst_en, mem_en, io_en}, 32'h1F, 'h004);
    chk("R4", {16'b0, lat_timer, cache_line}, 32'h0000_FFFF, 'h00C);
    chk("R5", {24'b0, irq_line}, 32'hFF, 'h03C);
    chk("R7", {12'b0, rmt_base[N*20-1 -: 20]}, 32'h000F_FFFF, 'h150);
    chk("R7", {26'b0, rmt_map}, 32'h3F, 'h104);
    chk("R8", {14'b0, loc_ctrl}, 32'h3FFF8, 'h200);
    chk("R9", {31'b0, loc_map[0]}, 32'h0, 'h204);
    chk("R9", {12'b0, loc_trans[19:0]}, 32'h0, 'h20C);
    chk("R10", {8'b0, cyc_addr}, 32'h00FF_FFFD, 'h280);
    chk("R11", {30'b0, rmt_err_en, loc_err_en}, 32'h3, 'h1C0);
    chk("R12", {27'b0, soft_rst, serr_irq_en, perr_irq_en, lerr_irq_en, prop_irq_en},
        32'h1F, 'h290);

    // R13: byte-select merges
    acc(1'b1, 'h290, 4'b0001, 32'h0, rd, ak, ph);
    acc(1'b0, 'h290, 4'h0, 32'h0, rd, ak, ph);
    chk("R13", rd, 32'h8000_0000, 'h290);
    acc(1'b1, 'h280, 4'b0100, 32'h0, rd, ak, ph);
    acc(1'b0, 'h280, 4'h0, 32'h0, rd, ak, ph);
    chk("R13", rd, 32'h0000_FFFD, 'h280);
    acc(1'b1, 'h00C, 4'b0010, 32'h0000_1200, rd, ak, ph);
    chk("R13", {16'b0, lat_timer, cache_line}, 32'h0000_12FF, 'h00C);
    acc(1'b1, 'h014, 4'b1000, 32'h0000_0000, rd, ak, ph);
    acc(1'b0, 'h104 + 16, 4'h0, 32'h0, rd, ak, ph);
    chk("R7", rd, 32'h00FF_F001, 'h114);
    acc(1'b1, 'h204, 4'hF, 32'h0, rd, ak, ph);
    acc(1'b0, 'h204, 4'h0, 32'h0, rd, ak, ph);
    chk("R9", rd, {RBASE, 12'h000}, 'h204);
    acc(1'b1, 'h3F0, 4'hF, 32'hFFFF_FFFF, rd, ak, ph);
    acc(1'b0, 'h3F0, 4'h0, 32'h0, rd, ak, ph);
    chk("R14", rd, 32'h0, 'h3F0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule